// File: doc/BRIEF.md
# Stimulus and Capture Sequencer

This block is the timing engine of a sensor front end. A single free-running period counter produces two compare outputs whose edges can be placed anywhere in the period. The block works with no processor involvement per sample. Each rise of the bias compare output moves to the next word of a small stored waveform and presents that word to a DAC port. Each rise of the sample compare output starts a burst of a fixed number of ADC conversions through a start/done handshake. The results are written into a local capture buffer.

A host writes the period, the two edge positions, the index of the last waveform word, the burst size and the waveform words. It then sets the enable bit and follows progress through a once-per-period interrupt. Two sticky status flags record completed periods and bursts that were requested while one was still running.

Register map (word addresses): 0 control, bit 0 enables the block; 1 period; 2 bias edge; 3 sample edge; 4 last waveform index; 5 burst size; 6 status. The upper half of the address space, 0x20 + i, writes waveform word i and reads capture entry i.

Top module: `stim_cap_seq`

## Requirements
- R1: While enabled, the period counter runs 0, 1, ..., P-1 and then returns to 0, where P is register 1. A period value of 0 behaves as 1. The interrupt rate gives P at the ports.
- R2: The bias output is high exactly while the block is enabled and the count is below register 2. The sample output does the same against register 3.
- R3: On each rise of the bias output, the next cycle shows the waveform word at the playback pointer on dac_word, with a one-cycle dac_load. The pointer then advances and returns to 0 after the index held in register 4. Word i is written at address 0x20 + i.
- R4: A rise of the sample output with a nonzero burst size (register 5) starts a burst of exactly that many conversions. Each adc_start lasts one cycle, and no new adc_start is issued until adc_done has been seen.
- R5: Each adc_done during a burst stores adc_result at capture index 0, 1, 2, ... in turn, readable at 0x20 + i. Status bits [15:8] give the number of samples taken in the current or latest burst.
- R6: A rise of the sample output while a burst is active is ignored and sets the overrun flag, status bit 1. The flag stays set until a write to register 6 with bit 1 set.
- R7: irq is a one-cycle pulse in the cycle whose count equals P-1. It sets status bit 0, which stays set until a write to register 6 with bit 0 set.
- R8: With the enable bit clear, the counter and playback pointer return to 0, both compare outputs and irq stay low, and any burst is abandoned with no further adc_start.
- R9: With a burst size of 0, a rise of the sample output starts no conversion.
- R10: After reset all registers, flags and outputs are zero. Registers 1 to 5 read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register or waveform write strobe |
| reg_waddr | input | ADDR_W | Write address |
| reg_wdata | input | DATA_W | Write data |
| reg_raddr | input | ADDR_W | Read address |
| reg_rdata | output | DATA_W | Read data, combinational from reg_raddr |
| pwm_bias | output | 1 | Bias compare output |
| pwm_sample | output | 1 | Sample compare output |
| dac_word | output | DAC_W | Current waveform word |
| dac_load | output | 1 | One-cycle strobe when dac_word changes |
| adc_start | output | 1 | One-cycle conversion request |
| adc_done | input | 1 | Conversion complete, one cycle |
| adc_result | input | ADC_W | Conversion result, valid with adc_done |
| irq | output | 1 | Terminal-count pulse |

## Verification
A wrong counter state shows within one period as a changed interval between irq pulses, or as a wrong number of high cycles on a compare output. A playback pointer that skips, fails to wrap or survives disable puts a wrong word on dac_word at the very next dac_load. A mistake in burst control shows at the handshake: an extra or missing adc_start, a start that overlaps an outstanding conversion, or a wrong sample count in the status register. The overrun flag is checked both as it is raised and after it is cleared.

// File: rtl/scs_pkg.sv
`timescale 1ns/1ps
package scs_pkg;
   typedef enum logic [1:0] {
      BST_IDLE  = 2'd0,
      BST_START = 2'd1,
      BST_WAIT  = 2'd2
   } burst_state_e;

   localparam int unsigned REG_CTRL     = 0;
   localparam int unsigned REG_PERIOD   = 1;
   localparam int unsigned REG_EDGE_A   = 2;
   localparam int unsigned REG_EDGE_B   = 3;
   localparam int unsigned REG_PAT_LAST = 4;
   localparam int unsigned REG_BURST    = 5;
   localparam int unsigned REG_STATUS   = 6;

   localparam int unsigned ST_TC_BIT    = 0;
   localparam int unsigned ST_OVR_BIT   = 1;
   localparam int unsigned ST_COUNT_LSB = 8;
endpackage

// File: rtl/scs_timebase.sv
`timescale 1ns/1ps
module scs_timebase #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned N_CH  = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic [CNT_W-1:0]       period,
   input  logic [N_CH*CNT_W-1:0]  edges,
   output logic [N_CH-1:0]        cmp,
   output logic [N_CH-1:0]        rise,
   output logic                   tc
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;
   logic [N_CH-1:0]  prev;

   // a zero period acts as a one-cycle period
   assign last = (period == '0) ? '0 : period - 1'b1;
   assign tc   = en && (cnt >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!en)        cnt <= '0;
      else if (cnt >= last) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic [CNT_W-1:0] edge_v;
      assign edge_v  = edges[c*CNT_W +: CNT_W];
      assign cmp[c]  = en && (cnt < edge_v);
      assign rise[c] = cmp[c] && !prev[c];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev[c] <= 1'b0;
         else        prev[c] <= cmp[c];
      end
   end

   AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cnt >= last) |=> (cnt == '0)) else $error("count did not wrap"); // R1
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cnt < last) |=> ((cnt == $past(cnt) + 1'b1) || (cnt == '0))) else $error("count skipped"); // R1
   AST_DIS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0)) else $error("count not cleared while disabled"); // R8
   AST_TC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (tc && last != '0 && $stable(period)) |=> !tc) else $error("terminal count longer than one cycle"); // R7
endmodule

// File: rtl/scs_player.sv
`timescale 1ns/1ps
module scs_player #(
   parameter int unsigned DAC_W = 12,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             step,
   input  logic [AW-1:0]    last,
   input  logic             mem_we,
   input  logic [AW-1:0]    mem_addr,
   input  logic [DAC_W-1:0] mem_wdata,
   output logic [DAC_W-1:0] dac_data,
   output logic             dac_load
);
   logic [DAC_W-1:0] words [DEPTH];
   logic [AW-1:0]    ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < DEPTH; w++) words[w] <= '0;
      end else if (mem_we) begin
         words[mem_addr] <= mem_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr      <= '0;
         dac_data <= '0;
         dac_load <= 1'b0;
      end else begin
         dac_load <= en && step;
         if (!en) begin
            ptr <= '0;
         end else if (step) begin
            dac_data <= words[ptr];
            ptr      <= (ptr >= last) ? '0 : ptr + 1'b1;
         end
      end
   end

   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && step && ptr >= last) |=> (ptr == '0)) else $error("pointer did not wrap"); // R3
   AST_PTR_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      (en && step && ptr < last) |=> ((ptr == $past(ptr) + 1'b1) || (ptr == '0))) else $error("pointer skipped"); // R3
   AST_PTR_DIS: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (ptr == '0)) else $error("pointer not cleared while disabled"); // R8
endmodule

// File: rtl/scs_burst.sv
`timescale 1ns/1ps
module scs_burst
   import scs_pkg::*;
#(
   parameter int unsigned ADC_W   = 12,
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned AW      = $clog2(DEPTH),
   parameter int unsigned BURST_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               trig,
   input  logic [BURST_W-1:0] burst_len,
   input  logic               adc_done,
   input  logic [ADC_W-1:0]   adc_data,
   input  logic [AW-1:0]      rd_idx,
   output logic               adc_start,
   output logic [ADC_W-1:0]   rd_word,
   output logic [BURST_W-1:0] count,
   output logic               busy_hit
);
   burst_state_e       state;
   logic [BURST_W-1:0] remain;
   logic [AW-1:0]      widx;
   logic [ADC_W-1:0]   cap [DEPTH];
   logic               take;

   assign adc_start = (state == BST_START);
   assign take      = (state == BST_WAIT) && adc_done;
   assign busy_hit  = en && trig && (state != BST_IDLE);
   assign rd_word   = cap[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= BST_IDLE;
         remain <= '0;
         widx   <= '0;
         count  <= '0;
      end else if (!en) begin
         state <= BST_IDLE;
      end else begin
         case (state)
            BST_IDLE: begin
               if (trig && burst_len != '0) begin
                  state  <= BST_START;
                  remain <= burst_len;
                  widx   <= '0;
                  count  <= '0;
               end
            end
            BST_START: state <= BST_WAIT;
            BST_WAIT: begin
               if (adc_done) begin
                  widx   <= widx + 1'b1;
                  count  <= count + 1'b1;
                  remain <= remain - 1'b1;
                  state  <= (remain == BURST_W'(1)) ? BST_IDLE : BST_START;
               end
            end
            default: state <= BST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) cap[k] <= '0;
      end else if (en && take) begin
         cap[widx] <= adc_data;
      end
   end

   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |=> !adc_start) else $error("start wider than one cycle"); // R4
   AST_HOLD_FOR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == BST_WAIT && !adc_done) |=> !adc_start) else $error("start issued before done"); // R4
   AST_BURST_END: assert property (@(posedge clk) disable iff (!rst_n)
      (take && remain == BURST_W'(1)) |=> (state == BST_IDLE)) else $error("burst ran past its size"); // R4
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && take) |=> (count == $past(count) + 1'b1)) else $error("sample count not advanced"); // R5
endmodule

// File: rtl/stim_cap_seq.sv
`timescale 1ns/1ps
module stim_cap_seq
   import scs_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned DAC_W     = 12,
   parameter int unsigned ADC_W     = 12,
   parameter int unsigned PAT_DEPTH = 16,
   parameter int unsigned CAP_DEPTH = 16,
   parameter int unsigned BURST_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_waddr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [ADDR_W-1:0] reg_raddr,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              pwm_bias,
   output logic              pwm_sample,
   output logic [DAC_W-1:0]  dac_word,
   output logic              dac_load,
   input  logic              adc_done,
   input  logic [ADC_W-1:0]  adc_result,
   output logic              adc_start,
   output logic              irq
);
   localparam int unsigned PAT_AW = $clog2(PAT_DEPTH);
   localparam int unsigned CAP_AW = $clog2(CAP_DEPTH);
   localparam int unsigned WIN_W  = ADDR_W - 1;

   if (DAC_W > DATA_W || ADC_W > DATA_W || CNT_W > DATA_W) begin : g_bad_width
      $error("converter and counter widths must fit the data bus");
   end
   if (ST_COUNT_LSB + BURST_W > DATA_W) begin : g_bad_count
      $error("sample count field does not fit the status word");
   end
   if ((1 << PAT_AW) != PAT_DEPTH || (1 << CAP_AW) != CAP_DEPTH || PAT_DEPTH < 2 || CAP_DEPTH < 2) begin : g_bad_depth
      $error("memory depths must be powers of two of at least 2");
   end
   if (PAT_AW > WIN_W || CAP_AW > WIN_W || ADDR_W < 4) begin : g_bad_addr
      $error("address window too small for the memories");
   end

   logic               en;
   logic [CNT_W-1:0]   period, edge_a, edge_b;
   logic [PAT_AW-1:0]  pat_last;
   logic [BURST_W-1:0] burst_len;
   logic               tc_flag, ovr_flag;
   logic               win_w, win_r, reg_sel_w;
   logic               clr_tc, clr_ovr;
   logic [1:0]         cmp, rise;
   logic               tc, busy_hit;
   logic [ADC_W-1:0]   cap_word;
   logic [BURST_W-1:0] count;

   assign win_w     = reg_waddr[ADDR_W-1];
   assign win_r     = reg_raddr[ADDR_W-1];
   assign reg_sel_w = reg_wr && !win_w;
   assign clr_tc    = reg_sel_w && (reg_waddr == ADDR_W'(REG_STATUS)) && reg_wdata[ST_TC_BIT];
   assign clr_ovr   = reg_sel_w && (reg_waddr == ADDR_W'(REG_STATUS)) && reg_wdata[ST_OVR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en        <= 1'b0;
         period    <= '0;
         edge_a    <= '0;
         edge_b    <= '0;
         pat_last  <= '0;
         burst_len <= '0;
      end else if (reg_sel_w) begin
         if (reg_waddr == ADDR_W'(REG_CTRL))     en        <= reg_wdata[0];
         if (reg_waddr == ADDR_W'(REG_PERIOD))   period    <= reg_wdata[CNT_W-1:0];
         if (reg_waddr == ADDR_W'(REG_EDGE_A))   edge_a    <= reg_wdata[CNT_W-1:0];
         if (reg_waddr == ADDR_W'(REG_EDGE_B))   edge_b    <= reg_wdata[CNT_W-1:0];
         if (reg_waddr == ADDR_W'(REG_PAT_LAST)) pat_last  <= reg_wdata[PAT_AW-1:0];
         if (reg_waddr == ADDR_W'(REG_BURST))    burst_len <= reg_wdata[BURST_W-1:0];
      end
   end

   // sticky flags: a new event in the clearing cycle wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc_flag  <= 1'b0;
         ovr_flag <= 1'b0;
      end else begin
         tc_flag  <= (tc_flag && !clr_tc) || tc;
         ovr_flag <= (ovr_flag && !clr_ovr) || busy_hit;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (win_r) begin
         reg_rdata[ADC_W-1:0] = cap_word;
      end else begin
         case (reg_raddr)
            ADDR_W'(REG_CTRL):     reg_rdata[0] = en;
            ADDR_W'(REG_PERIOD):   reg_rdata[CNT_W-1:0] = period;
            ADDR_W'(REG_EDGE_A):   reg_rdata[CNT_W-1:0] = edge_a;
            ADDR_W'(REG_EDGE_B):   reg_rdata[CNT_W-1:0] = edge_b;
            ADDR_W'(REG_PAT_LAST): reg_rdata[PAT_AW-1:0] = pat_last;
            ADDR_W'(REG_BURST):    reg_rdata[BURST_W-1:0] = burst_len;
            ADDR_W'(REG_STATUS): begin
               reg_rdata[ST_TC_BIT]  = tc_flag;
               reg_rdata[ST_OVR_BIT] = ovr_flag;
               reg_rdata[ST_COUNT_LSB +: BURST_W] = count;
            end
            default: reg_rdata = '0;
         endcase
      end
   end

   scs_timebase #(.CNT_W(CNT_W), .N_CH(2)) u_timebase (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .period (period),
      .edges  ({edge_b, edge_a}),
      .cmp    (cmp),
      .rise   (rise),
      .tc     (tc)
   );

   scs_player #(.DAC_W(DAC_W), .DEPTH(PAT_DEPTH), .AW(PAT_AW)) u_player (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .step      (rise[0]),
      .last      (pat_last),
      .mem_we    (reg_wr && win_w),
      .mem_addr  (reg_waddr[PAT_AW-1:0]),
      .mem_wdata (reg_wdata[DAC_W-1:0]),
      .dac_data  (dac_word),
      .dac_load  (dac_load)
   );

   scs_burst #(.ADC_W(ADC_W), .DEPTH(CAP_DEPTH), .AW(CAP_AW), .BURST_W(BURST_W)) u_burst (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .trig      (rise[1]),
      .burst_len (burst_len),
      .adc_done  (adc_done),
      .adc_data  (adc_result),
      .rd_idx    (reg_raddr[CAP_AW-1:0]),
      .adc_start (adc_start),
      .rd_word   (cap_word),
      .count     (count),
      .busy_hit  (busy_hit)
   );

   assign pwm_bias   = cmp[0];
   assign pwm_sample = cmp[1];
   assign irq        = tc;

   AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> tc_flag) else $error("interrupt flag not set"); // R7
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_hit |=> ovr_flag) else $error("overrun flag not set"); // R6
   AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag && !clr_ovr) |=> ovr_flag) else $error("overrun flag lost"); // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !$past(en)) |-> (!adc_start && !irq && !pwm_bias && !pwm_sample)) else $error("activity while disabled"); // R8
endmodule

// File: tb/stim_cap_seq_tb.sv
`timescale 1ns/1ps
module stim_cap_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [5:0]  reg_waddr = '0;
   logic [15:0] reg_wdata = '0;
   logic [5:0]  reg_raddr = '0;
   logic [15:0] reg_rdata;
   logic        pwm_bias, pwm_sample, dac_load, adc_start, irq;
   logic [11:0] dac_word;
   logic        adc_done = 1'b0;
   logic [11:0] adc_result = '0;

   int total = 0;
   int bad = 0;
   logic [11:0] dac_q[$];
   logic [11:0] adc_q[$];
   int n_start = 0;
   int n_samp = 0;
   int adc_delay = 2;
   logic [11:0] seq = 12'h5A0;

   always #10 clk = ~clk;

   stim_cap_seq u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .pwm_bias(pwm_bias), .pwm_sample(pwm_sample), .dac_word(dac_word),
      .dac_load(dac_load), .adc_done(adc_done), .adc_result(adc_result),
      .adc_start(adc_start), .irq(irq)
   );

   function automatic logic [11:0] pat(int i);
      return 12'(12'h300 + i * 13);
   endfunction

   task automatic chk(input string req, input longint act, input longint exp, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_raddr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   // scoreboard monitor for the waveform port
   always @(negedge clk) begin
      logic [11:0] e;
      if (dac_load === 1'b1) begin
         if (dac_q.size() == 0) chk("R3", dac_word, 'hFFFF, "unexpected DAC load");
         else begin
            e = dac_q.pop_front();
            chk("R3", dac_word, e, "DAC word");
         end
      end
   end

   // converter model: answers each start after adc_delay cycles
   initial begin
      forever begin
         @(negedge clk);
         if (adc_done) adc_done = 1'b0;
         if (adc_start === 1'b1) begin
            n_start++;
            for (int k = 0; k < adc_delay; k++) begin
               @(negedge clk);
               if (adc_start === 1'b1) chk("R4", 1, 0, "start while conversion pending");
            end
            adc_result = seq;
            adc_done = 1'b1;
            adc_q.push_back(seq);
            seq = seq + 12'd7;
            n_samp++;
         end
      end
   end

   initial begin
      #(200000 * 20);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] d;
      int na, nb, ni, s0, m0;
      bit ok;

      wait_cycles(3);
      rst_n = 1'b1;
      wait_cycles(2);
      // R10 / R8: reset state
      chk("R10", {irq, dac_load, adc_start, pwm_bias, pwm_sample}, 0, "outputs after reset");
      chk("R10", dac_word, 0, "dac word after reset");
      rd(6, d); chk("R10", d, 0, "status after reset");
      rd(1, d); chk("R10", d, 0, "period after reset");

      // phase 1: playback, timing, no conversions
      for (int i = 0; i < 16; i++) wr(6'(32 + i), 16'(pat(i)));
      wr(1, 20); wr(2, 5); wr(3, 10); wr(4, 3); wr(5, 0);
      rd(1, d); chk("R10", d, 20, "period readback");
      rd(3, d); chk("R10", d, 10, "sample edge readback");
      rd(4, d); chk("R10", d, 3, "last index readback");
      s0 = n_start;
      dac_q.push_back(pat(0)); dac_q.push_back(pat(1)); dac_q.push_back(pat(2));
      dac_q.push_back(pat(3)); dac_q.push_back(pat(0));
      wr(0, 1);
      ok = 0;
      for (int i = 0; i < 100 && !ok; i++) begin @(negedge clk); if (irq) ok = 1; end
      chk("R7", ok, 1, "first interrupt seen");
      na = 0; nb = 0; ni = 0;
      for (int i = 1; i <= 20; i++) begin
         @(negedge clk);
         if (pwm_bias) na++;
         if (pwm_sample) nb++;
         if (irq) ni++;
         if (i == 1) chk("R7", irq, 0, "interrupt one cycle wide");
         if (i == 20) chk("R1", irq, 1, "interrupt after one period");
      end
      chk("R1", ni, 1, "one interrupt per period");
      chk("R2", na, 5, "bias high cycles");
      chk("R2", nb, 10, "sample high cycles");
      for (int i = 0; i < 200 && dac_q.size() != 0; i++) @(negedge clk);
      chk("R3", dac_q.size(), 0, "playback wrapped through pattern");
      wait_cycles(2);
      wr(0, 0);
      ni = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (pwm_bias || pwm_sample || irq) ni++;
      end
      chk("R8", ni, 0, "outputs quiet while disabled");
      dac_q.push_back(pat(0));
      wr(0, 1);
      for (int i = 0; i < 50 && dac_q.size() != 0; i++) @(negedge clk);
      chk("R8", dac_q.size(), 0, "playback restarts at word 0");
      wait_cycles(2);
      wr(0, 0);
      chk("R9", n_start - s0, 0, "no conversion with zero burst size");
      rd(6, d); chk("R7", d[0], 1, "period flag set");
      wr(6, 16'h0001);
      rd(6, d); chk("R7", d[0], 0, "period flag cleared");

      // phase 2: single burst
      wr(2, 0); wr(1, 40); wr(5, 3);
      adc_delay = 2;
      adc_q.delete();
      s0 = n_start; m0 = n_samp;
      wr(0, 1);
      for (int i = 0; i < 300 && n_samp != m0 + 3; i++) @(negedge clk);
      wait_cycles(3);
      wr(0, 0);
      chk("R4", n_start - s0, 3, "conversions per burst");
      rd(6, d); chk("R5", d[15:8], 3, "sample count");
      chk("R6", d[1], 0, "no overrun on a lone burst");
      for (int i = 0; i < 3; i++) begin
         logic [11:0] e;
         e = (adc_q.size() != 0) ? adc_q.pop_front() : 12'hFFF;
         rd(6'(32 + i), d);
         chk("R5", d, e, "captured sample");
      end

      // phase 3: overrun
      wr(1, 20); wr(5, 6);
      adc_delay = 6;
      wr(0, 1);
      wait_cycles(25);
      rd(6, d); chk("R6", d[1], 1, "overrun flag set");
      wr(6, 16'h0002);
      rd(6, d); chk("R6", d[1], 0, "overrun flag cleared");
      wait_cycles(20);
      rd(6, d); chk("R6", d[1], 1, "overrun flag set again");
      wr(0, 0);
      wait_cycles(10);
      s0 = n_start;
      wait_cycles(40);
      chk("R8", n_start - s0, 0, "burst abandoned on disable");

      // phase 4: zero period
      wr(1, 0); wr(3, 0); wr(5, 0);
      wr(0, 1);
      wait_cycles(3);
      ni = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (irq) ni++; end
      chk("R1", ni, 10, "zero period behaves as one");
      wr(0, 0);
      wait_cycles(3);
      chk("R3", dac_q.size(), 0, "no pending DAC words");

      summary();
      $finish;
   end
endmodule